// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit-Manipulation Unit

This combinational unit computes the second-page bit-manipulation operations of an 8-bit processor on one register operand. A 2-bit class input picks one of four groups: the shift/rotate/swap group, bit test, bit clear or bit set. A 3-bit code then picks the shift operation, or a 3-bit index picks the target bit. The unit receives the operand and the four incoming flags: zero (Z), subtract (N), half-carry (H) and carry (C). It returns the new operand value, a write-back strobe for the register that supplied the operand, and each flag's new value with its own write enable.

Instruction decode and the register file sit outside the unit. The surrounding pipeline writes `res_o` back to the source register when `wb_o` is high. It updates a flag only when that flag's enable is high. When a flag's enable is low, the unit passes the incoming flag value through on that flag's output.

Top module: `prb_unit`

## Requirements
- R1: Class 0 (shift group) with code 0 rotates left circularly: old bit 7 goes to bit 0, and C becomes old bit 7.
- R2: Class 0, code 1 rotates right circularly: old bit 0 goes to bit 7, and C becomes old bit 0.
- R3: Class 0, code 2 rotates left through carry: the incoming C enters bit 0, and C becomes old bit 7.
- R4: Class 0, code 3 rotates right through carry: the incoming C enters bit 7, and C becomes old bit 0.
- R5: Class 0, code 4 shifts left arithmetically: bit 0 becomes 0, and C becomes old bit 7.
- R6: Class 0, code 5 shifts right arithmetically: bit 7 keeps its value, and C becomes old bit 0.
- R7: Class 0, code 7 shifts right logically: bit 7 becomes 0, and C becomes old bit 0.
- R8: Class 0, code 6 exchanges the upper and lower 4-bit halves, and C becomes 0.
- R9: Every class-0 operation asserts `wb_o` and all four flag enables, clears N and H, and sets Z exactly when the 8-bit result is zero.
- R10: Class 1 (bit test) sets Z to the inverse of operand bit `idx_i`, sets H to 1 and clears N. It enables only Z, N and H, keeps `wb_o` low, passes the incoming C to `c_o`, and passes the operand through unchanged on `res_o`.
- R11: Class 2 (bit clear) returns the operand with bit `idx_i` forced to 0. It asserts `wb_o`, asserts no flag enable, and passes all four incoming flags through.
- R12: Class 3 (bit set) returns the operand with bit `idx_i` forced to 1. It asserts `wb_o`, asserts no flag enable, and passes all four incoming flags through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cls_i | input | 2 | Operation class: 0 shift group, 1 test, 2 clear, 3 set |
| op_i | input | 3 | Shift-group code (used in class 0) |
| idx_i | input | 3 | Target bit index (used in classes 1 to 3) |
| opnd_i | input | 8 | Register operand |
| z_i | input | 1 | Incoming zero flag |
| n_i | input | 1 | Incoming subtract flag |
| h_i | input | 1 | Incoming half-carry flag |
| c_i | input | 1 | Incoming carry flag |
| res_o | output | 8 | Result value |
| wb_o | output | 1 | Write result back to the operand register |
| z_o | output | 1 | New zero flag |
| n_o | output | 1 | New subtract flag |
| h_o | output | 1 | New half-carry flag |
| c_o | output | 1 | New carry flag |
| z_we | output | 1 | Zero flag update enable |
| n_we | output | 1 | Subtract flag update enable |
| h_we | output | 1 | Half-carry flag update enable |
| c_we | output | 1 | Carry flag update enable |

## Verification
The bench sweeps every class, code, bit index, operand value and incoming flag combination, so each corner case below is covered.

Rotates through carry must take the old C and not the shifted-out bit. A design that mixed these up would give wrong results whenever C differs from the edge bit. Z must come from the shifted result and not be forced low. A design that forced it low would miss zero results such as 0x80 shifted left or 0x01 shifted right. The arithmetic right shift must copy bit 7, which shows up as a wrong sign bit on negative operands. Bit test must leave C, the result and `wb_o` untouched, so a leaking write-back or carry update would show at the ports. Bit clear and bit set must use each of the eight indices and leave every flag enable low.

// File: rtl/prb_pkg.sv
package prb_pkg;

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'd0,
    CLS_TEST  = 2'd1,
    CLS_CLEAR = 2'd2,
    CLS_SET   = 2'd3
  } cls_e;

  typedef enum logic [2:0] {
    SH_ROL_CIRC  = 3'd0,
    SH_ROR_CIRC  = 3'd1,
    SH_ROL_CARRY = 3'd2,
    SH_ROR_CARRY = 3'd3,
    SH_LEFT_ARITH  = 3'd4,
    SH_RIGHT_ARITH = 3'd5,
    SH_HALF_SWAP   = 3'd6,
    SH_RIGHT_LOGIC = 3'd7
  } shop_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

endpackage

// File: rtl/prb_shift_core.sv
module prb_shift_core #(
  parameter int W = 8
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  output logic [W-1:0] y_o,
  output logic         cy_o,
  output logic         zero_o
);
  import prb_pkg::*;

  localparam int HALF = W / 2;

  function automatic logic [W-1:0] rot_left(input logic [W-1:0] v, input logic fill);
    return {v[W-2:0], fill};
  endfunction

  function automatic logic [W-1:0] rot_right(input logic [W-1:0] v, input logic fill);
    return {fill, v[W-1:1]};
  endfunction

  function automatic logic [W-1:0] half_swap(input logic [W-1:0] v);
    return {v[HALF-1:0], v[W-1:HALF]};
  endfunction

  logic msb_out;
  logic lsb_out;
  assign msb_out = a_i[W-1];
  assign lsb_out = a_i[0];

  always_comb begin
    y_o  = a_i;
    cy_o = 1'b0;
    unique case (shop_e'(op_i))
      SH_ROL_CIRC:    begin y_o = rot_left(a_i, msb_out);   cy_o = msb_out; end
      SH_ROR_CIRC:    begin y_o = rot_right(a_i, lsb_out);  cy_o = lsb_out; end
      SH_ROL_CARRY:   begin y_o = rot_left(a_i, cin_i);     cy_o = msb_out; end
      SH_ROR_CARRY:   begin y_o = rot_right(a_i, cin_i);    cy_o = lsb_out; end
      SH_LEFT_ARITH:  begin y_o = rot_left(a_i, 1'b0);      cy_o = msb_out; end
      SH_RIGHT_ARITH: begin y_o = rot_right(a_i, msb_out);  cy_o = lsb_out; end
      SH_HALF_SWAP:   begin y_o = half_swap(a_i);           cy_o = 1'b0;    end
      SH_RIGHT_LOGIC: begin y_o = rot_right(a_i, 1'b0);     cy_o = lsb_out; end
      default:        begin y_o = a_i;                      cy_o = 1'b0;    end
    endcase
  end

  assign zero_o = (y_o == '0);

  always_comb begin
    if (op_i == SH_LEFT_ARITH)  p_sla_fill_r5: assert (y_o[0] == 1'b0);
    if (op_i == SH_RIGHT_ARITH) p_sra_sign_r6: assert (y_o[W-1] == a_i[W-1]);
    if (op_i == SH_RIGHT_LOGIC) p_srl_fill_r7: assert (y_o[W-1] == 1'b0);
    if (op_i == SH_HALF_SWAP)   p_swap_carry_r8: assert (!cy_o && $countones(y_o) == $countones(a_i));
    if (op_i <= 3'd1)           p_circ_ones_r1: assert ($countones(y_o) == $countones(a_i));
  end

endmodule

// File: rtl/prb_bit_core.sv
module prb_bit_core #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [IW-1:0] idx_i,
  input  logic [W-1:0]  a_i,
  output logic          picked_o,
  output logic [W-1:0]  cleared_o,
  output logic [W-1:0]  setv_o
);

  logic [W-1:0] mask;

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask[g] = (idx_i == IW'(g));
  end

  assign picked_o  = |(a_i & mask);
  assign cleared_o = a_i & ~mask;
  assign setv_o    = a_i | mask;

  always_comb begin
    p_one_hot_r10: assert ($onehot(mask));
    p_clear_touch_r11: assert ($countones(cleared_o ^ a_i) <= 1 && cleared_o[idx_i] == 1'b0);
    p_set_touch_r12: assert ($countones(setv_o ^ a_i) <= 1 && setv_o[idx_i] == 1'b1);
  end

endmodule

// File: rtl/prb_unit.sv
module prb_unit (
  input  logic [1:0] cls_i,
  input  logic [2:0] op_i,
  input  logic [2:0] idx_i,
  input  logic [7:0] opnd_i,
  input  logic       z_i,
  input  logic       n_i,
  input  logic       h_i,
  input  logic       c_i,
  output logic [7:0] res_o,
  output logic       wb_o,
  output logic       z_o,
  output logic       n_o,
  output logic       h_o,
  output logic       c_o,
  output logic       z_we,
  output logic       n_we,
  output logic       h_we,
  output logic       c_we
);
  import prb_pkg::*;

  localparam int W  = 8;
  localparam int IW = $clog2(W);

  logic [W-1:0] sh_y;
  logic         sh_cy;
  logic         sh_zero;
  logic         bit_picked;
  logic [W-1:0] bit_cleared;
  logic [W-1:0] bit_setv;

  prb_shift_core #(.W(W)) u_shift (
    .op_i   (op_i),
    .a_i    (opnd_i),
    .cin_i  (c_i),
    .y_o    (sh_y),
    .cy_o   (sh_cy),
    .zero_o (sh_zero)
  );

  prb_bit_core #(.W(W), .IW(IW)) u_bit (
    .idx_i     (idx_i),
    .a_i       (opnd_i),
    .picked_o  (bit_picked),
    .cleared_o (bit_cleared),
    .setv_o    (bit_setv)
  );

  flags_t fin;
  flags_t fout;
  flags_t fen;

  assign fin = '{z: z_i, n: n_i, h: h_i, c: c_i};

  always_comb begin
    res_o = opnd_i;
    wb_o  = 1'b0;
    fout  = fin;
    fen   = '0;
    unique case (cls_e'(cls_i))
      CLS_SHIFT: begin
        res_o = sh_y;
        wb_o  = 1'b1;
        fout  = '{z: sh_zero, n: 1'b0, h: 1'b0, c: sh_cy};
        fen   = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b1};
      end
      CLS_TEST: begin
        fout  = '{z: ~bit_picked, n: 1'b0, h: 1'b1, c: c_i};
        fen   = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b0};
      end
      CLS_CLEAR: begin
        res_o = bit_cleared;
        wb_o  = 1'b1;
      end
      CLS_SET: begin
        res_o = bit_setv;
        wb_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign z_o  = fout.z;
  assign n_o  = fout.n;
  assign h_o  = fout.h;
  assign c_o  = fout.c;
  assign z_we = fen.z;
  assign n_we = fen.n;
  assign h_we = fen.h;
  assign c_we = fen.c;

  always_comb begin
    if (cls_i == CLS_SHIFT) p_shift_zero_r9: assert (z_o == (res_o == 8'h00) && !n_o && !h_o);
    if (cls_i == CLS_TEST)  p_test_nowrite_r10: assert (!wb_o && !c_we && c_o == c_i && res_o == opnd_i);
    if (cls_i == CLS_CLEAR) p_clear_noflag_r11: assert (!(z_we | n_we | h_we | c_we));
    if (cls_i == CLS_SET)   p_set_noflag_r12: assert (!(z_we | n_we | h_we | c_we));
  end

endmodule

// File: tb/prb_unit_test.sv
module prb_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cls_i = '0;
  logic [2:0] op_i = '0;
  logic [2:0] idx_i = '0;
  logic [7:0] opnd_i = '0;
  logic       z_i = 1'b0, n_i = 1'b0, h_i = 1'b0, c_i = 1'b0;
  logic [7:0] res_o;
  logic       wb_o, z_o, n_o, h_o, c_o, z_we, n_we, h_we, c_we;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  prb_unit uut (
    .cls_i(cls_i), .op_i(op_i), .idx_i(idx_i), .opnd_i(opnd_i),
    .z_i(z_i), .n_i(n_i), .h_i(h_i), .c_i(c_i),
    .res_o(res_o), .wb_o(wb_o), .z_o(z_o), .n_o(n_o), .h_o(h_o), .c_o(c_o),
    .z_we(z_we), .n_we(n_we), .h_we(h_we), .c_we(c_we)
  );

  // expected packing: {res[7:0], wb, z, n, h, c, z_we, n_we, h_we, c_we}
  function automatic logic [16:0] model(input int cls, input int op, input int idx,
                                        input int v, input int fz, input int fn,
                                        input int fh, input int fc);
    int r, cy, b, wb, ez, en, eh, ec, we;
    r = v; wb = 0; ez = fz; en = fn; eh = fh; ec = fc; we = 0;
    b = (v / (1 << idx)) % 2;
    if (cls == 0) begin
      case (op)
        0: begin r = (v * 2) % 256 + v / 128;      cy = v / 128; end   // R1
        1: begin r = v / 2 + (v % 2) * 128;        cy = v % 2;   end   // R2
        2: begin r = (v * 2) % 256 + fc;           cy = v / 128; end   // R3
        3: begin r = v / 2 + fc * 128;             cy = v % 2;   end   // R4
        4: begin r = (v * 2) % 256;                cy = v / 128; end   // R5
        5: begin r = v / 2 + (v / 128) * 128;      cy = v % 2;   end   // R6
        6: begin r = (v % 16) * 16 + v / 16;       cy = 0;       end   // R8
        default: begin r = v / 2;                  cy = v % 2;   end   // R7
      endcase
      wb = 1; ez = (r == 0); en = 0; eh = 0; ec = cy; we = 15;          // R9
    end else if (cls == 1) begin
      ez = 1 - b; en = 0; eh = 1; we = 14;                             // R10
    end else if (cls == 2) begin
      r = v - b * (1 << idx); wb = 1;                                  // R11
    end else begin
      r = v + (1 - b) * (1 << idx); wb = 1;                            // R12
    end
    return {r[7:0], wb[0], ez[0], en[0], eh[0], ec[0], we[3:0]};
  endfunction

  function automatic string rtag(input int cls, input int op);
    if (cls == 1) return "R10";
    if (cls == 2) return "R11";
    if (cls == 3) return "R12";
    case (op)
      0: return "R1/R9";
      1: return "R2/R9";
      2: return "R3/R9";
      3: return "R4/R9";
      4: return "R5/R9";
      5: return "R6/R9";
      6: return "R8/R9";
      default: return "R7/R9";
    endcase
  endfunction

  task automatic apply_and_check(input int cls, input int op, input int idx,
                                 input int v, input int f);
    logic [16:0] exp_v, got_v;
    @(negedge clk);
    cls_i = 2'(cls); op_i = 3'(op); idx_i = 3'(idx); opnd_i = 8'(v);
    z_i = f[3]; n_i = f[2]; h_i = f[1]; c_i = f[0];
    #1;
    exp_v = model(cls, op, idx, v, f / 8, (f / 4) % 2, (f / 2) % 2, f % 2);
    got_v = {res_o, wb_o, z_o, n_o, h_o, c_o, z_we, n_we, h_we, c_we};
    n_checks++;
    if (got_v !== exp_v) begin
      n_fails++;
      $display("FAIL %s cls=%0d op=%0d idx=%0d v=%02h f=%01h actual=%05h expected=%05h",
               rtag(cls, op), cls, op, idx, v, f, got_v, exp_v);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // quiet all-zero inputs: shift-group rotate of zero gives zero with Z set (R1, R9)
    apply_and_check(0, 0, 0, 0, 0);
    for (int cls = 0; cls < 4; cls++) begin
      for (int sel = 0; sel < 8; sel++) begin
        for (int v = 0; v < 256; v++) begin
          for (int f = 0; f < 16; f++) begin
            if (cls == 0) apply_and_check(cls, sel, (v + f) % 8, v, f);
            else          apply_and_check(cls, (v + f) % 8, sel, v, f);
          end
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule